// File: doc/BRIEF.md
# External Interrupt Request Collector

This block gathers external interrupt requests for a single processor core. It keeps a 32-bit pending-request register and a 32-bit enable mask. It drives one level-sensitive interrupt line that is high whenever an enabled request is pending.

Any agent on the system bus can raise a request. It does so with a full-word write whose five least significant bits carry an interrupt number. That number selects one pending bit, with numbering that runs from the top of the word down: number 0 is bit 31 and number 31 is bit 0. A bus read returns the pending word.

The core side has two ports. A clear port removes every pending bit written as one. A mask port loads a new enable mask. A local timer alarm raises interrupt number 0. Ordering and vectoring of pending requests belong to logic outside this block.

Top module: `extIrqCollector`

## Requirements
- R1: After reset the pending register and the mask read as zero, the interrupt line is low and no bus response is pending.
- R2: An accepted bus write with all four strobes set makes pending bit (31 − wdata[4:0]) one on the next clock edge and leaves every other pending bit unchanged.
- R3: Bits 31..5 of the bus write data have no effect on which pending bit is set.
- R4: An accepted bus read with all four strobes set gives, in the cycle after acceptance, busRespValid high, busErr low and busRdata equal to the pending word as it stood at acceptance.
- R5: An accepted bus access whose strobe is not 4'b1111 gives busRespValid and busErr high in the next cycle and changes neither the pending register nor the mask.
- R6: A core clear write makes zero every pending bit that is one in coreClrData and leaves the others as they were.
- R7: A core mask write replaces the whole mask with coreMaskData.
- R8: irqOut is high exactly when the bitwise AND of pending and mask is nonzero, so it follows every set, clear or mask change from the next cycle on.
- R9: A timerAlarm pulse makes pending bit 31 (interrupt number 0) one.
- R10: When a bus set and a core clear hit the same bit in one cycle, the bit ends up set.
- R11: A bus set and a timer alarm in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus request valid |
| busReady | output | 1 | Slave ready; the request is accepted when valid and ready are both high |
| busWrite | input | 1 | 1 = write (raise a request), 0 = read |
| busStrb | input | 4 | Byte strobes; only 4'b1111 is legal |
| busWdata | input | 32 | Write data; bits 4..0 carry the interrupt number |
| busRespValid | output | 1 | Response valid, one cycle after acceptance |
| busErr | output | 1 | Response error for an access that is not a full word |
| busRdata | output | 32 | Read data (the pending word) |
| coreClrValid | input | 1 | Core clear strobe |
| coreClrData | input | 32 | Bits to clear, one per set bit |
| coreMaskValid | input | 1 | Core mask load strobe |
| coreMaskData | input | 32 | New enable mask |
| timerAlarm | input | 1 | Timer alarm pulse; raises interrupt number 0 |
| corePending | output | 32 | Current pending register |
| coreMask | output | 32 | Current enable mask |
| irqOut | output | 1 | Level interrupt to the core |

## Verification
Two situations are the hardest to reach from the ports. In one, a bus set and a core clear land on the same bit in the same cycle. In the other, the timer alarm and a bus write arrive together. The bench reaches both by driving the clear port, the timer input and the bus request on one negative edge, so all of them are sampled by the same rising edge. It then reads the pending word back. A partial-strobe access is also issued while the pending register and the mask are both nonzero, so that a wrong update would show up as a changed value.

// File: rtl/extIrqPkg.sv
package extIrqPkg;
  localparam int REG_W    = 32;
  localparam int IDX_W    = $clog2(REG_W);
  localparam int STRB_W   = REG_W / 8;
  localparam int TIMER_NUM = 0;

  typedef struct packed {
    logic             setEn;
    logic [IDX_W-1:0] setIdx;
    logic             timerEn;
    logic             clrEn;
    logic             maskEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqBusCtrl.sv
module irqBusCtrl
  import extIrqPkg::*;
#(
  parameter int REG_W_P  = REG_W,
  parameter int STRB_W_P = STRB_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  output logic                busReady,
  input  logic                busWrite,
  input  logic [STRB_W_P-1:0] busStrb,
  input  logic [REG_W_P-1:0]  busWdata,
  output logic                busRespValid,
  output logic                busErr,
  output logic [REG_W_P-1:0]  busRdata,
  input  logic                coreClrValid,
  input  logic                coreMaskValid,
  input  logic                timerAlarm,
  input  logic [REG_W_P-1:0]  pendingQ,
  output ctrlStrobe_t         ctl
);
  localparam int IDX_WL = $clog2(REG_W_P);

  logic accept;
  logic fullWord;
  logic unusedWdataHi;

  assign busReady = 1'b1;
  assign accept   = busValid & busReady;
  assign fullWord = &busStrb;
  assign unusedWdataHi = ^busWdata[REG_W_P-1:IDX_WL];

  always_comb begin
    ctl         = '0;
    ctl.setEn   = accept & busWrite & fullWord;
    ctl.setIdx  = ~busWdata[IDX_WL-1:0];
    ctl.timerEn = timerAlarm;
    ctl.clrEn   = coreClrValid;
    ctl.maskEn  = coreMaskValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRespValid <= 1'b0;
      busErr       <= 1'b0;
      busRdata     <= '0;
    end else begin
      busRespValid <= accept;
      busErr       <= accept & ~fullWord;
      if (accept && !busWrite && fullWord) busRdata <= pendingQ;
    end
  end

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busRespValid); // R4
  AST_BAD_STRB_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !fullWord) |=> busErr); // R5
endmodule

// File: rtl/irqRegFile.sv
module irqRegFile
  import extIrqPkg::*;
#(
  parameter int REG_W_P = REG_W,
  parameter int TIMER_P = TIMER_NUM
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        ctl,
  input  logic [REG_W_P-1:0] clrData,
  input  logic [REG_W_P-1:0] maskData,
  output logic [REG_W_P-1:0] pendingQ,
  output logic [REG_W_P-1:0] maskQ,
  output logic               irqOut
);
  localparam int IDX_WL  = $clog2(REG_W_P);
  localparam int TIMER_B = REG_W_P - 1 - TIMER_P;

  logic [REG_W_P-1:0] setVec;
  logic [REG_W_P-1:0] clrVec;
  logic [REG_W_P-1:0] pendingD;

  for (genvar i = 0; i < REG_W_P; i++) begin : gSetBit
    if (i == TIMER_B) begin : gTimer
      assign setVec[i] = (ctl.setEn && ctl.setIdx == IDX_WL'(i)) || ctl.timerEn;
    end else begin : gPlain
      assign setVec[i] = ctl.setEn && ctl.setIdx == IDX_WL'(i);
    end
  end

  assign clrVec   = ctl.clrEn ? clrData : '0;
  assign pendingD = (pendingQ & ~clrVec) | setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= '0;
      maskQ    <= '0;
    end else begin
      pendingQ <= pendingD;
      if (ctl.maskEn) maskQ <= maskData;
    end
  end

  assign irqOut = |(pendingQ & maskQ);

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setEn |=> pendingQ[$past(ctl.setIdx)]); // R10
  AST_TIMER_TOP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.timerEn |=> pendingQ[TIMER_B]); // R9
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.maskEn |=> maskQ == $past(maskData)); // R7
  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrEn && !ctl.setEn && !ctl.timerEn) |=> (pendingQ & $past(clrData)) == '0); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.maskEn |=> $stable(maskQ)); // R5
endmodule

// File: rtl/extIrqCollector.sv
module extIrqCollector
  import extIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  output logic              busReady,
  input  logic              busWrite,
  input  logic [STRB_W-1:0] busStrb,
  input  logic [REG_W-1:0]  busWdata,
  output logic              busRespValid,
  output logic              busErr,
  output logic [REG_W-1:0]  busRdata,
  input  logic              coreClrValid,
  input  logic [REG_W-1:0]  coreClrData,
  input  logic              coreMaskValid,
  input  logic [REG_W-1:0]  coreMaskData,
  input  logic              timerAlarm,
  output logic [REG_W-1:0]  corePending,
  output logic [REG_W-1:0]  coreMask,
  output logic              irqOut
);
  ctrlStrobe_t ctl;

  irqBusCtrl #(.REG_W_P(REG_W), .STRB_W_P(STRB_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busReady(busReady), .busWrite(busWrite),
    .busStrb(busStrb), .busWdata(busWdata),
    .busRespValid(busRespValid), .busErr(busErr), .busRdata(busRdata),
    .coreClrValid(coreClrValid), .coreMaskValid(coreMaskValid),
    .timerAlarm(timerAlarm), .pendingQ(corePending), .ctl(ctl)
  );

  irqRegFile #(.REG_W_P(REG_W), .TIMER_P(TIMER_NUM)) u_regs (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .clrData(coreClrData), .maskData(coreMaskData),
    .pendingQ(corePending), .maskQ(coreMask), .irqOut(irqOut)
  );

  AST_BAD_STRB_NOEFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busReady && busStrb != '1 && !coreClrValid && !coreMaskValid && !timerAlarm)
      |=> $stable(corePending) && $stable(coreMask)); // R5
  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (coreMask == '0) |-> !irqOut); // R8
endmodule

// File: tb/extIrqCollector_tb.sv
module extIrqCollector_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busReady;
  logic        busWrite = 1'b0;
  logic [3:0]  busStrb = 4'h0;
  logic [31:0] busWdata = '0;
  logic        busRespValid;
  logic        busErr;
  logic [31:0] busRdata;
  logic        coreClrValid = 1'b0;
  logic [31:0] coreClrData = '0;
  logic        coreMaskValid = 1'b0;
  logic [31:0] coreMaskData = '0;
  logic        timerAlarm = 1'b0;
  logic [31:0] corePending;
  logic [31:0] coreMask;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  extIrqCollector u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busReady(busReady),
    .busWrite(busWrite), .busStrb(busStrb), .busWdata(busWdata),
    .busRespValid(busRespValid), .busErr(busErr), .busRdata(busRdata),
    .coreClrValid(coreClrValid), .coreClrData(coreClrData),
    .coreMaskValid(coreMaskValid), .coreMaskData(coreMaskData),
    .timerAlarm(timerAlarm), .corePending(corePending), .coreMask(coreMask),
    .irqOut(irqOut)
  );

  localparam int NVEC = 5;
  // {write data, expected cumulative pending}
  localparam logic [63:0] VECS [NVEC] = '{
    {32'h0000_0000, 32'h8000_0000},
    {32'h0000_001F, 32'h8000_0001},
    {32'hFFFF_FFE5, 32'h8400_0001},
    {32'h1234_5670, 32'h8400_8001},
    {32'h0000_0000, 32'h8400_8001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives at a negative edge, lets one rising edge sample, returns at the next negative edge.
  task automatic step();
    @(posedge clk);
    #1;
    busValid = 1'b0; coreClrValid = 1'b0; coreMaskValid = 1'b0; timerAlarm = 1'b0;
    @(negedge clk);
  endtask

  task automatic busReq(input logic wr, input logic [3:0] strb, input logic [31:0] data);
    busValid = 1'b1; busWrite = wr; busStrb = strb; busWdata = data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pending", corePending, 32'h0);
    check("R1 mask", coreMask, 32'h0);
    check("R1 irq", {31'h0, irqOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 resp", {31'h0, busRespValid}, 32'h0);

    // R2 / R3 vector walk
    for (int k = 0; k < NVEC; k++) begin
      busReq(1'b1, 4'hF, VECS[k][63:32]);
      step();
      check(k == 2 ? "R3 high bits ignored" : "R2 set bit", corePending, VECS[k][31:0]);
      check("R2 resp ok", {30'h0, busRespValid, busErr}, 32'h2);
    end

    // R4 read
    busReq(1'b0, 4'hF, 32'h0);
    step();
    check("R4 rdata", busRdata, 32'h8400_8001);
    check("R4 resp", {30'h0, busRespValid, busErr}, 32'h2);

    // R7 / R8 mask load
    coreMaskValid = 1'b1; coreMaskData = 32'h0000_8000;
    step();
    check("R7 mask", coreMask, 32'h0000_8000);
    check("R8 irq high", {31'h0, irqOut}, 32'h1);

    // R5 bad strobe write and read with nonzero state
    busReq(1'b1, 4'h3, 32'h0000_0002);
    step();
    check("R5 err write", {30'h0, busRespValid, busErr}, 32'h3);
    check("R5 pending kept", corePending, 32'h8400_8001);
    check("R5 mask kept", coreMask, 32'h0000_8000);
    busReq(1'b0, 4'hE, 32'h0);
    step();
    check("R5 err read", {30'h0, busRespValid, busErr}, 32'h3);

    // R6 / R8 clear
    coreClrValid = 1'b1; coreClrData = 32'h0000_8000;
    step();
    check("R6 clear", corePending, 32'h8400_0001);
    check("R8 irq low", {31'h0, irqOut}, 32'h0);
    coreMaskValid = 1'b1; coreMaskData = 32'h0000_0001;
    step();
    check("R7 replace", coreMask, 32'h0000_0001);
    check("R8 irq again", {31'h0, irqOut}, 32'h1);

    // R9 timer
    coreClrValid = 1'b1; coreClrData = 32'hFFFF_FFFF;
    step();
    check("R6 clear all", corePending, 32'h0);
    timerAlarm = 1'b1;
    step();
    check("R9 timer", corePending, 32'h8000_0000);

    // R10 set beats clear on same bit
    coreClrValid = 1'b1; coreClrData = 32'h8000_0000;
    busReq(1'b1, 4'hF, 32'h0);
    step();
    check("R10 set wins", corePending, 32'h8000_0000);

    // R11 timer plus bus write together
    coreClrValid = 1'b1; coreClrData = 32'hFFFF_FFFF;
    step();
    timerAlarm = 1'b1;
    busReq(1'b1, 4'hF, 32'h0000_001F);
    step();
    check("R11 both set", corePending, 32'h8000_0001);
    check("R8 irq bit0", {31'h0, irqOut}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule